// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog. Software arms it by selecting an interval and setting an enable bit, then has to keep restarting it. If the countdown runs out while the watchdog is still enabled and allowed to reset, the block sends a one-cycle reset request to the system reset logic. Time is counted in half-second ticks, which a prescaler derives from the block clock. The parameter `TICK_DIV` sets how many clock cycles make one tick.

A build-time parameter `KEYED` chooses between two register layouts. The simple layout has a control word and a mode word. The keyed layout adds three words of plain storage (an interrupt-enable word, an interrupt-status word and a configuration word). It also requires a 12-bit key inside every control write. Intervals come from a fixed, non-linear table of 4-bit indices. The countdown is one-shot: after it expires it stays idle until the next restart.

Top module: `keyed_wdt`

## Requirements
- R1: A restart loads the reload value for the 4-bit interval index. Indices 0 to 11 give 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28 and 32 ticks, and each tick is `TICK_DIV` clock cycles. The reset pulse appears after the clock edge that lies exactly reload×`TICK_DIV` edges after the restart edge.
- R2: A restart with index 12 to 15 loads no count. It stops any countdown in progress, and no reset pulse follows.
- R3: The reset pulse lasts exactly one cycle. The counter does not reload itself after expiry.
- R4: In the keyed layout, a control write takes effect only when `wdata[12:1]` equals 12'hA57. Any other control write is ignored entirely.
- R5: A control write that is accepted and has `wdata[0]` set restarts the countdown, using the stored interval index. The control word always reads as zero. In the simple layout every control write is accepted.
- R6: A mode write stores all 32 bits. Only a 0-to-1 change of mode bit 0 (enable) restarts the countdown from the newly written index. Rewriting an enable bit that is already 1 does not restart it.
- R7: Expiry raises the pulse only if, at that moment, mode bit 0 is set and the reset-enable bit is also set. The reset-enable bit is configuration bit 0 in the keyed layout and mode bit 1 in the simple layout.
- R8: Keyed layout offsets: interrupt enable at 0x00, interrupt status at 0x04, control at 0x10, configuration at 0x14 and mode at 0x18, with the index in mode bits 7:4. Simple layout offsets: control at 0x0 and mode at 0x4, with the index in mode bits 6:3. The storage words read back what was written.
- R9: Unmapped, misaligned or out-of-span offsets read as zero, and writes to them change nothing.
- R10: Reset clears every register to zero and leaves the counter idle, with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle 32-bit write strobe |
| rdEn | input | 1 | Read enable; rdata is combinational |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not selected |
| sysRstPulse | output | 1 | One-cycle system reset request |

## Verification
The bench instantiates the block twice. One copy is built with `KEYED=1` and the other with `KEYED=0`, and both use `TICK_DIV=4` and `ADDR_W=6`. The short divider keeps even the 32-tick interval within 128 cycles, so the bench can walk every table entry and measure its exact edge count. With `ADDR_W=6` the bench can also drive offsets beyond the keyed span. Running both layouts side by side exercises each one's key rule, reset-enable bit position and index field.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int TICKS_W = 6;

  typedef struct packed {
    logic               load;
    logic               stop;
    logic [TICKS_W-1:0] reloadTicks;
  } kickStrobe_t;

  // Non-linear interval table, in half-second ticks
  function automatic logic [TICKS_W-1:0] intervalTicks(input logic [3:0] idx);
    case (idx)
      4'd0:    intervalTicks = 6'd1;
      4'd1:    intervalTicks = 6'd2;
      4'd2:    intervalTicks = 6'd4;
      4'd3:    intervalTicks = 6'd6;
      4'd4:    intervalTicks = 6'd8;
      4'd5:    intervalTicks = 6'd10;
      4'd6:    intervalTicks = 6'd12;
      4'd7:    intervalTicks = 6'd16;
      4'd8:    intervalTicks = 6'd20;
      4'd9:    intervalTicks = 6'd24;
      4'd10:   intervalTicks = 6'd28;
      4'd11:   intervalTicks = 6'd32;
      default: intervalTicks = 6'd0;
    endcase
  endfunction

  function automatic logic intervalValid(input logic [3:0] idx);
    intervalValid = (idx < 4'd12);
  endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int KEYED  = 1,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output kickStrobe_t       kick,
  output logic              armOk
);

  localparam logic [11:0]       KEY_VAL    = 12'hA57;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = ADDR_W'((KEYED != 0) ? 'h10 : 'h0);
  localparam logic [ADDR_W-1:0] OFF_MODE   = ADDR_W'((KEYED != 0) ? 'h18 : 'h4);
  localparam logic [ADDR_W-1:0] OFF_IRQEN  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_IRQSTA = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_CFG    = ADDR_W'('h14);

  logic [31:0] modeQ;
  logic [31:0] irqEnQ;
  logic [31:0] irqStaQ;
  logic [31:0] cfgQ;
  logic        keyOk;
  logic        rstEnBit;
  logic [3:0]  idxNow;
  logic [3:0]  idxNew;

  logic ctrlHit;
  logic modeHit;
  logic ctrlKick;
  logic enableRise;
  logic anyKick;
  logic [3:0] kickIdx;

  assign ctrlHit    = wrEn && (addr == OFF_CTRL);
  assign modeHit    = wrEn && (addr == OFF_MODE);
  assign ctrlKick   = ctrlHit && keyOk && wdata[0];
  assign enableRise = modeHit && wdata[0] && !modeQ[0];
  assign anyKick    = ctrlKick || enableRise;
  assign kickIdx    = enableRise ? idxNew : idxNow;

  always_comb begin
    kick.load        = anyKick && intervalValid(kickIdx);
    kick.stop        = anyKick && !intervalValid(kickIdx);
    kick.reloadTicks = intervalTicks(kickIdx);
  end

  assign armOk = modeQ[0] && rstEnBit;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= '0;
    else if (modeHit) modeQ <= wdata;
  end

  generate
    if (KEYED != 0) begin : gKeyed
      always_ff @(posedge clk) begin
        if (!rstN) begin
          irqEnQ  <= '0;
          irqStaQ <= '0;
          cfgQ    <= '0;
        end else if (wrEn) begin
          if (addr == OFF_IRQEN)  irqEnQ  <= wdata;
          if (addr == OFF_IRQSTA) irqStaQ <= wdata;
          if (addr == OFF_CFG)    cfgQ    <= wdata;
        end
      end
      assign keyOk    = (wdata[12:1] == KEY_VAL);
      assign rstEnBit = cfgQ[0];
      assign idxNow   = modeQ[7:4];
      assign idxNew   = wdata[7:4];
    end else begin : gSimple
      assign irqEnQ   = '0;
      assign irqStaQ  = '0;
      assign cfgQ     = '0;
      assign keyOk    = 1'b1;
      assign rstEnBit = modeQ[1];
      assign idxNow   = modeQ[6:3];
      assign idxNew   = wdata[6:3];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      if (addr == OFF_MODE)                          rdata = modeQ;
      else if ((KEYED != 0) && (addr == OFF_IRQEN))  rdata = irqEnQ;
      else if ((KEYED != 0) && (addr == OFF_IRQSTA)) rdata = irqStaQ;
      else if ((KEYED != 0) && (addr == OFF_CFG))    rdata = cfgQ;
    end
  end

  // R4: a control write carrying a wrong key never reaches the counter
  a_r4_key_gate: assert property (@(posedge clk) disable iff (!rstN)
    ((KEYED != 0) && wrEn && (addr == OFF_CTRL) && (wdata[12:1] != KEY_VAL))
      |-> !(kick.load || kick.stop));

  // R6: rewriting an already-set enable bit never restarts
  a_r6_no_rekick: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == OFF_MODE) && modeQ[0]) |-> !(kick.load || kick.stop));

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
  import kwdt_pkg::*;
#(
  parameter int TICK_DIV = 50_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  kickStrobe_t kick,
  input  logic        armOk,
  output logic        sysRstPulse
);

  localparam int                PRE_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]   preQ;
  logic [TICKS_W-1:0] cntQ;
  logic               runQ;
  logic               pulseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ   <= '0;
      cntQ   <= '0;
      runQ   <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= 1'b0;
      if (kick.load) begin
        preQ <= '0;
        cntQ <= kick.reloadTicks;
        runQ <= 1'b1;
      end else if (kick.stop) begin
        preQ <= '0;
        cntQ <= '0;
        runQ <= 1'b0;
      end else if (runQ) begin
        if (preQ == PRE_LAST) begin
          preQ <= '0;
          cntQ <= cntQ - 1'b1;
          if (cntQ == TICKS_W'(1)) begin
            runQ   <= 1'b0;
            pulseQ <= armOk;
          end
        end else begin
          preQ <= preQ + 1'b1;
        end
      end
    end
  end

  assign sysRstPulse = pulseQ;

  // R1: a load starts the countdown from the table value with a fresh prescaler
  a_r1_reload: assert property (@(posedge clk) disable iff (!rstN)
    kick.load |=> (runQ && (cntQ == $past(kick.reloadTicks)) && (preQ == '0)));

  // R2: an invalid index leaves the counter idle
  a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    kick.stop |=> !runQ);

  // R3: the request is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sysRstPulse |=> !sysRstPulse);

  // R3: a running counter never sits at zero
  a_r3_run_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> (cntQ != '0));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int KEYED    = 1,
  parameter int TICK_DIV = 50_000_000,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              sysRstPulse
);

  kickStrobe_t kick;
  logic        armOk;

  kwdt_regs #(.KEYED(KEYED), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .kick(kick), .armOk(armOk)
  );

  kwdt_count #(.TICK_DIV(TICK_DIV)) count_i (
    .clk(clk), .rstN(rstN), .kick(kick), .armOk(armOk),
    .sysRstPulse(sysRstPulse)
  );

endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;

  localparam int TD = 4;
  localparam logic [5:0] K_IRQEN = 6'h00, K_IRQSTA = 6'h04, K_CTRL = 6'h10,
                         K_CFG = 6'h14, K_MODE = 6'h18;
  localparam logic [5:0] S_CTRL = 6'h00, S_MODE = 6'h04;
  localparam int EXPT [16] = '{1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28, 32, 0, 0, 0, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrK = 1'b0, rdK = 1'b0, wrS = 1'b0, rdS = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdataK, rdataS;
  logic        pulseK, pulseS;
  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  keyed_wdt #(.KEYED(1), .TICK_DIV(TD), .ADDR_W(6)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrK), .rdEn(rdK), .addr(addr),
    .wdata(wdata), .rdata(rdataK), .sysRstPulse(pulseK)
  );

  keyed_wdt #(.KEYED(0), .TICK_DIV(TD), .ADDR_W(6)) dutS_i (
    .clk(clk), .rstN(rstN), .wrEn(wrS), .rdEn(rdS), .addr(addr),
    .wdata(wdata), .rdata(rdataS), .sysRstPulse(pulseS)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input bit keyed, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (keyed) wrK = 1'b1; else wrS = 1'b1;
    @(negedge clk);
    wrK = 1'b0; wrS = 1'b0;
  endtask

  task automatic rd(input bit keyed, input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    if (keyed) rdK = 1'b1; else rdS = 1'b1;
    #1;
    d = keyed ? rdataK : rdataS;
    rdK = 1'b0; rdS = 1'b0;
  endtask

  // Returns the negedge index after which the pulse is first seen, 0 if none
  task automatic waitPulse(input bit keyed, input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (keyed ? pulseK : pulseS) begin
        k = i;
        break;
      end
    end
    if (k != 0) begin
      @(negedge clk);
      chk("R3 pulse width", keyed ? pulseK : pulseS, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    rd(1, K_MODE, v);  chk("R10 keyed mode", v, 0);
    rd(1, K_CFG, v);   chk("R10 keyed cfg", v, 0);
    rd(1, K_IRQEN, v); chk("R10 keyed irqen", v, 0);
    rd(0, S_MODE, v);  chk("R10 simple mode", v, 0);
    chk("R10 no pulse", pulseK | pulseS, 0);

    // R8: storage words; R5: control reads zero
    wr(1, K_IRQEN, 32'h0000_0005);  rd(1, K_IRQEN, v);  chk("R8 irqen", v, 32'h5);
    wr(1, K_IRQSTA, 32'hA5A5_0F0F); rd(1, K_IRQSTA, v); chk("R8 irqsta", v, 32'hA5A5_0F0F);
    wr(1, K_CFG, 32'h0000_0001);    rd(1, K_CFG, v);    chk("R8 cfg", v, 32'h1);
    rd(1, K_CTRL, v); chk("R5 ctrl reads zero", v, 0);

    // R9: unmapped, misaligned, beyond span
    wr(1, 6'h0C, 32'h3);   rd(1, 6'h0C, v); chk("R9 unmapped", v, 0);
    wr(1, 6'h19, 32'hFF);  rd(1, K_MODE, v); chk("R9 misaligned", v, 0);
    wr(1, 6'h20, 32'hFF);  rd(1, 6'h20, v); chk("R9 beyond span", v, 0);
    rd(1, 6'h1C, v); chk("R9 span end", v, 0);
    wr(0, 6'h08, 32'hFF);  rd(0, 6'h08, v); chk("R9 simple beyond", v, 0);
    rd(0, S_MODE, v); chk("R9 simple mode untouched", v, 0);

    // R1/R2: every interval index on the keyed layout
    for (int i = 0; i < 16; i++) begin
      wr(1, K_MODE, 32'h0);
      wr(1, K_MODE, (32'(i) << 4) | 32'h1);
      waitPulse(1, EXPT[i] * TD + 8, k);
      chk((i < 12) ? "R1 interval" : "R2 invalid index", k, EXPT[i] * TD);
    end

    // R3: one-shot
    wr(1, K_MODE, 32'h0);
    wr(1, K_MODE, 32'h01);
    waitPulse(1, 20, k);  chk("R3 first expiry", k, TD);
    waitPulse(1, 60, k);  chk("R3 no reload", k, 0);

    // R4: bad key ignored
    wr(1, K_MODE, 32'h0);
    wr(1, K_MODE, 32'h21);
    repeat (7) @(negedge clk);
    wr(1, K_CTRL, (32'h0A56 << 1) | 32'h1);
    waitPulse(1, 30, k);  chk("R4 bad key ignored", k, 7);

    // R5: good key with restart bit
    wr(1, K_MODE, 32'h0);
    wr(1, K_MODE, 32'h21);
    repeat (7) @(negedge clk);
    wr(1, K_CTRL, (32'h0A57 << 1) | 32'h1);
    waitPulse(1, 30, k);  chk("R5 good key restart", k, 16);

    // R5: good key without restart bit
    wr(1, K_MODE, 32'h0);
    wr(1, K_MODE, 32'h21);
    repeat (7) @(negedge clk);
    wr(1, K_CTRL, (32'h0A57 << 1));
    waitPulse(1, 30, k);  chk("R5 no restart bit", k, 7);

    // R6: rewriting set enable does not restart, value stored
    wr(1, K_MODE, 32'h0);
    wr(1, K_MODE, 32'h21);
    repeat (7) @(negedge clk);
    wr(1, K_MODE, 32'h1234_0021);
    waitPulse(1, 30, k);  chk("R6 no rekick", k, 7);
    rd(1, K_MODE, v);     chk("R6 mode stored", v, 32'h1234_0021);

    // R2: restart with invalid stored index stops a running count
    wr(1, K_MODE, 32'h0);
    wr(1, K_MODE, 32'h31);
    repeat (3) @(negedge clk);
    wr(1, K_MODE, 32'hD1);
    wr(1, K_CTRL, (32'h0A57 << 1) | 32'h1);
    waitPulse(1, 40, k);  chk("R2 stop running", k, 0);

    // R7: reset-enable clear, then enable clear
    wr(1, K_CFG, 32'h0);
    wr(1, K_MODE, 32'h0);
    wr(1, K_MODE, 32'h01);
    waitPulse(1, 20, k);  chk("R7 cfg clear", k, 0);
    wr(1, K_CFG, 32'h1);
    wr(1, K_MODE, 32'h0);
    wr(1, K_MODE, 32'h11);
    wr(1, K_MODE, 32'h10);
    waitPulse(1, 20, k);  chk("R7 enable clear", k, 0);

    // Simple layout: R1/R8 field positions
    wr(0, S_MODE, 32'h0);
    wr(0, S_MODE, (32'h1 << 3) | 32'h3);
    waitPulse(0, 20, k);  chk("R8 simple interval", k, 2 * TD);
    rd(0, S_MODE, v);     chk("R8 simple mode", v, 32'hB);

    // R5: simple control restarts with any upper bits
    wr(0, S_MODE, 32'h0);
    wr(0, S_MODE, (32'h1 << 3) | 32'h3);
    repeat (3) @(negedge clk);
    wr(0, S_CTRL, 32'h0000_0001);
    waitPulse(0, 20, k);  chk("R5 simple restart", k, 8);

    // R7: simple reset-enable is mode bit 1
    wr(0, S_MODE, 32'h0);
    wr(0, S_MODE, 32'h1);
    waitPulse(0, 20, k);  chk("R7 simple rst enable clear", k, 0);

    // R10: reset in mid-count
    wr(1, K_MODE, 32'h0);
    wr(1, K_MODE, 32'h21);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rd(1, K_MODE, v);     chk("R10 mode cleared", v, 0);
    rd(1, K_IRQSTA, v);   chk("R10 irqsta cleared", v, 0);
    waitPulse(1, 30, k);  chk("R10 no pulse after reset", k, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule